// File: doc/BRIEF.md
# Linked-list recurrent prefetch sequencer

This block is the in-order half of a pointer-chasing prefetch engine. Software first loads a small kernel of load descriptors into a table through a configuration write port. Each descriptor holds a used flag, a flag that marks the load which fetches the next-node pointer, a load PC and an address offset. Writing the head pointer of a list into the base buffer starts a walk. Whenever the block is idle and the base buffer holds an address, it moves that address into its base register and takes a private copy of every used descriptor. It then emits one prefetch request per cycle, with address equal to base plus offset, into a request queue. Downstream logic drains that queue.

When the next-node load of an iteration returns, the returned pointer goes back into the base buffer and drives the following iteration. A NULL pointer ends the walk. Iterations therefore run strictly one after another. The memory side, the cache lookup and the handling of loads that hang off the traversal loads all sit outside this block.

Top module: `lds_prefetch_seq`

## Requirements
- R1: After reset the request queue is empty (`pfq_valid` low) and every kernel slot reads as unused, so no request is issued until a kernel and a root exist.
- R2: A cycle with `cfg_wr` high stores `cfg_used`, `cfg_rec`, `cfg_pc` and `cfg_off` into slot `cfg_slot`. Only slots with the used flag set take part in later iterations.
- R3: A cycle with `root_wr` high and a nonzero `root_addr` places the address in the base buffer. A zero root address is ignored.
- R4: When the sequencer is idle and the base buffer is not empty, one cycle pops the head into the base register and snapshots the used slots. The first request is then visible at the queue head after the second rising edge that follows the edge capturing a root into an empty, idle block.
- R5: An iteration issues at most one request per cycle, one per used slot, in ascending slot order. Each request carries address = base + offset (modulo 2^32), plus the slot's PC and its next-node flag (`pfq_rec` = 1 for the next-node load).
- R6: A cycle with `ret_valid` high and a nonzero `ret_ptr` places the pointer in the base buffer, and it becomes the base of a later iteration.
- R7: A returned pointer of zero is not stored, so the walk ends and no further request appears.
- R8: While the request queue holds its full depth, issue stalls and the pending slot is kept. No request is lost, duplicated or reordered.
- R9: A root or returned pointer that arrives while the base buffer holds its full depth is discarded.
- R10: The request queue is first in, first out. `pfq_pop` removes the head, and `pfq_pop` on an empty queue has no effect.
- R11: If a nonzero root and a nonzero returned pointer arrive in the same cycle, the root is stored and the pointer is discarded.
- R12: Kernel writes made while an iteration is in progress do not change that iteration's remaining requests. They apply from the next iteration on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Kernel slot write strobe |
| cfg_slot | input | 2 | Kernel slot index |
| cfg_used | input | 1 | Slot takes part in iterations |
| cfg_rec | input | 1 | Slot is the next-node load |
| cfg_pc | input | 32 | Load PC stored in the slot |
| cfg_off | input | 32 | Address offset stored in the slot |
| root_wr | input | 1 | Root pointer write strobe |
| root_addr | input | 32 | Root pointer of the list |
| ret_valid | input | 1 | Next-node load returned data |
| ret_ptr | input | 32 | Returned next-node pointer |
| pfq_valid | output | 1 | Request queue holds an entry |
| pfq_addr | output | 32 | Head request address |
| pfq_pc | output | 32 | Head request PC |
| pfq_rec | output | 1 | Head request is the next-node load |
| pfq_pop | input | 1 | Remove the head request |

## Verification
A root captured at a clock edge reaches the base register one edge later, and its first request reaches the queue head the edge after that. The bench samples `pfq_valid` on the falling edges after each of those two rising edges to pin this latency down. Every later request is compared in queue order against a list computed from base plus offset, so results that depend on stall length or drain rate are checked by order, not by a fixed cycle. Drops and ignored inputs are judged after a settling window of several cycles in which the queue must stay empty or end with no extra entries. Stall and snapshot cases first fill the queue, so the sequencer is known to be parked mid-iteration when the disturbing input arrives.

// File: rtl/lps_pkg.sv
package lps_pkg;
  parameter int ADDR_W = 32;
  parameter int PC_W   = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PC_W-1:0]   pc_t;

  // one kernel descriptor
  typedef struct packed {
    logic  used;
    logic  rec;
    pc_t   pc;
    addr_t off;
  } kent_t;

  // one prefetch request
  typedef struct packed {
    addr_t addr;
    pc_t   pc;
    logic  rec;
  } preq_t;
endpackage

// File: rtl/lps_fifo.sv
module lps_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(1);
      if (do_pop)  rp <= rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);

  a_r9_full_keeps: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && wp == $past(wp)));
endmodule

// File: rtl/lps_kernel.sv
module lps_kernel
  import lps_pkg::*;
#(
  parameter int K = 4,
  localparam int IW = $clog2(K)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [IW-1:0] slot,
  input  kent_t         din,
  output kent_t         tbl [K]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < K; i++) tbl[i].used <= 1'b0;
    end else if (wr) begin
      tbl[slot] <= din;
    end
  end

  a_r2_slot_written: assert property (@(posedge clk) disable iff (rst)
    wr |=> (tbl[$past(slot)] == $past(din)));
endmodule

// File: rtl/lps_issue.sv
module lps_issue
  import lps_pkg::*;
#(
  parameter int K = 4,
  localparam int IW = $clog2(K)
) (
  input  logic  clk,
  input  logic  rst,
  input  kent_t tbl [K],
  input  logic  base_avail,
  input  addr_t base_head,
  output logic  base_take,
  input  logic  rq_full,
  output logic  rq_push,
  output preq_t rq_data
);
  addr_t         base_q;
  kent_t         snap [K];
  logic [K-1:0]  pend;
  logic [IW-1:0] sel;
  logic          busy;

  assign busy      = |pend;
  assign base_take = !busy && base_avail;
  assign rq_push   = busy && !rq_full;

  // lowest pending slot goes first
  always_comb begin
    sel = '0;
    for (int i = K - 1; i >= 0; i--) begin
      if (pend[i]) sel = IW'(i);
    end
  end

  always_comb begin
    rq_data.addr = base_q + snap[sel].off;
    rq_data.pc   = snap[sel].pc;
    rq_data.rec  = snap[sel].rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      base_q <= '0;
    end else if (base_take) begin
      base_q <= base_head;
      for (int i = 0; i < K; i++) pend[i] <= tbl[i].used;
    end else if (rq_push) begin
      pend[sel] <= 1'b0;
    end
  end

  // snapshot has no reset: only read while its pend bit is set
  always_ff @(posedge clk) begin
    if (base_take) snap <= tbl;
  end

  a_r4_base_load: assert property (@(posedge clk) disable iff (rst)
    base_take |=> (base_q == $past(base_head)));

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && rq_full) |=> (pend == $past(pend) && base_q == $past(base_q)));

  a_r5_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
    rq_push |=> ($countones(pend) + 1 == $countones($past(pend))));

  a_r12_base_steady: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(base_q));
endmodule

// File: rtl/lds_prefetch_seq.sv
module lds_prefetch_seq
  import lps_pkg::*;
#(
  parameter int KSLOTS     = 4,
  parameter int BASE_DEPTH = 4,
  parameter int REQ_DEPTH  = 4,
  localparam int SLOT_W    = $clog2(KSLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_used,
  input  logic              cfg_rec,
  input  logic [PC_W-1:0]   cfg_pc,
  input  logic [ADDR_W-1:0] cfg_off,
  input  logic              root_wr,
  input  logic [ADDR_W-1:0] root_addr,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_ptr,
  output logic              pfq_valid,
  output logic [ADDR_W-1:0] pfq_addr,
  output logic [PC_W-1:0]   pfq_pc,
  output logic              pfq_rec,
  input  logic              pfq_pop
);
  kent_t cfg_ent;
  kent_t tbl [KSLOTS];
  logic  root_ok, ret_ok;
  logic  bf_push, bf_empty, bf_full, bf_take;
  addr_t bf_wdata, bf_head;
  logic  rq_push, rq_empty, rq_full;
  preq_t rq_wdata, rq_head;

  assign cfg_ent = '{used: cfg_used, rec: cfg_rec, pc: cfg_pc, off: cfg_off};

  lps_kernel #(.K(KSLOTS)) u_kernel (
    .clk  (clk),
    .rst  (rst),
    .wr   (cfg_wr),
    .slot (cfg_slot),
    .din  (cfg_ent),
    .tbl  (tbl)
  );

  // root has priority over a returned pointer; NULL never enters
  assign root_ok  = root_wr && (root_addr != '0);
  assign ret_ok   = ret_valid && (ret_ptr != '0);
  assign bf_push  = root_ok || ret_ok;
  assign bf_wdata = root_ok ? root_addr : ret_ptr;

  lps_fifo #(.W(ADDR_W), .DEPTH(BASE_DEPTH)) u_base_buf (
    .clk   (clk),
    .rst   (rst),
    .push  (bf_push),
    .wdata (bf_wdata),
    .pop   (bf_take),
    .rdata (bf_head),
    .empty (bf_empty),
    .full  (bf_full)
  );

  lps_issue #(.K(KSLOTS)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .tbl        (tbl),
    .base_avail (!bf_empty),
    .base_head  (bf_head),
    .base_take  (bf_take),
    .rq_full    (rq_full),
    .rq_push    (rq_push),
    .rq_data    (rq_wdata)
  );

  lps_fifo #(.W($bits(preq_t)), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk   (clk),
    .rst   (rst),
    .push  (rq_push),
    .wdata (rq_wdata),
    .pop   (pfq_pop),
    .rdata (rq_head),
    .empty (rq_empty),
    .full  (rq_full)
  );

  assign pfq_valid = !rq_empty;
  assign pfq_addr  = rq_head.addr;
  assign pfq_pc    = rq_head.pc;
  assign pfq_rec   = rq_head.rec;

  a_r7_null_ignored: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_ptr == '0 && !root_wr && bf_empty) |=> bf_empty);

  a_r3_zero_root_ignored: assert property (@(posedge clk) disable iff (rst)
    (root_wr && root_addr == '0 && !ret_valid && bf_empty) |=> bf_empty);

  a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
    (bf_full && bf_push && !bf_take) |=> bf_full);

  a_r10_head_kept: assert property (@(posedge clk) disable iff (rst)
    (pfq_valid && !pfq_pop) |=> (pfq_valid && pfq_addr == $past(pfq_addr)));
endmodule

// File: tb/lds_prefetch_seq_test.sv
module lds_prefetch_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic        cfg_used = 1'b0;
  logic        cfg_rec = 1'b0;
  logic [31:0] cfg_pc = '0;
  logic [31:0] cfg_off = '0;
  logic        root_wr = 1'b0;
  logic [31:0] root_addr = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_ptr = '0;
  logic        pfq_valid;
  logic [31:0] pfq_addr;
  logic [31:0] pfq_pc;
  logic        pfq_rec;
  logic        pfq_pop = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench-side kernel model and expected request list
  logic        m_used [4];
  logic        m_rec  [4];
  logic [31:0] m_pc   [4];
  logic [31:0] m_off  [4];
  logic [31:0] e_addr [$];
  logic [31:0] e_pc   [$];
  logic        e_rec  [$];

  always #5 clk = ~clk;

  lds_prefetch_seq uut (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_used(cfg_used), .cfg_rec(cfg_rec),
    .cfg_pc(cfg_pc), .cfg_off(cfg_off),
    .root_wr(root_wr), .root_addr(root_addr),
    .ret_valid(ret_valid), .ret_ptr(ret_ptr),
    .pfq_valid(pfq_valid), .pfq_addr(pfq_addr), .pfq_pc(pfq_pc), .pfq_rec(pfq_rec),
    .pfq_pop(pfq_pop)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int s, input logic u, input logic r, input logic [31:0] pc, input logic [31:0] off);
    cfg_wr = 1'b1; cfg_slot = 2'(s); cfg_used = u; cfg_rec = r; cfg_pc = pc; cfg_off = off;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_used[s] = u; m_rec[s] = r; m_pc[s] = pc; m_off[s] = off;
  endtask

  task automatic root(input logic [31:0] a);
    root_wr = 1'b1; root_addr = a;
    @(negedge clk);
    root_wr = 1'b0;
  endtask

  task automatic ret(input logic [31:0] p);
    ret_valid = 1'b1; ret_ptr = p;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic expect_iter(input logic [31:0] b);
    for (int i = 0; i < 4; i++) begin
      if (m_used[i]) begin
        e_addr.push_back(b + m_off[i]);
        e_pc.push_back(m_pc[i]);
        e_rec.push_back(m_rec[i]);
      end
    end
  endtask

  task automatic pop_check(input string req);
    logic [31:0] xa, xp;
    logic        xr;
    int          w;
    xa = e_addr.pop_front(); xp = e_pc.pop_front(); xr = e_rec.pop_front();
    w = 0;
    while (!pfq_valid && w < 40) begin
      @(negedge clk);
      w++;
    end
    chk(pfq_valid, {req, " request present"}, 32'(pfq_valid), 32'h1);
    chk(pfq_addr == xa, {req, " address"}, pfq_addr, xa);
    chk(pfq_pc == xp && pfq_rec == xr, {req, " pc/type"}, {pfq_pc[30:0], pfq_rec}, {xp[30:0], xr});
    pfq_pop = 1'b1;
    @(negedge clk);
    pfq_pop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (e_addr.size() != 0) pop_check(req);
    cyc(8);
    chk(!pfq_valid, {req, " no extra requests"}, 32'(pfq_valid), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_used[i] = 1'b0; m_rec[i] = 1'b0; m_pc[i] = '0; m_off[i] = '0;
    end
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: empty queue after reset, and a root alone makes no request
    chk(!pfq_valid, "R1 reset empty", 32'(pfq_valid), 32'h0);
    root(32'h0000_0400);
    cyc(6);
    chk(!pfq_valid, "R1 unused kernel", 32'(pfq_valid), 32'h0);

    // R2: program slots 0,2,3; slot 1 unused
    cfg(0, 1'b1, 1'b0, 32'h100, 32'h4);
    cfg(1, 1'b0, 1'b0, 32'h1ff, 32'h80);
    cfg(2, 1'b1, 1'b1, 32'h104, 32'h8);
    cfg(3, 1'b1, 1'b0, 32'h108, 32'h10);

    // R4: latency from root capture to queue head
    root(32'h0000_1000);
    chk(!pfq_valid, "R4 one edge after root", 32'(pfq_valid), 32'h0);
    cyc(1);
    chk(!pfq_valid, "R4 load edge", 32'(pfq_valid), 32'h0);
    cyc(1);
    chk(pfq_valid, "R4 first request due", 32'(pfq_valid), 32'h1);
    expect_iter(32'h0000_1000);
    drain("R2 R5 R10");

    // R6: returned pointer drives the next iteration
    ret(32'h0000_2000);
    expect_iter(32'h0000_2000);
    drain("R6");

    // R7: NULL return ends the walk; R10: pop on empty has no effect
    ret(32'h0);
    cyc(8);
    chk(!pfq_valid, "R7 null ends walk", 32'(pfq_valid), 32'h0);
    pfq_pop = 1'b1;
    cyc(2);
    pfq_pop = 1'b0;
    root(32'h0000_2400);
    expect_iter(32'h0000_2400);
    drain("R10 pop on empty");

    // R3: zero root ignored
    root(32'h0);
    cyc(8);
    chk(!pfq_valid, "R3 zero root", 32'(pfq_valid), 32'h0);

    // R5: sweep slot masks, offsets and bases, including wrap-around
    for (int j = 0; j < 16; j++) begin
      for (int i = 0; i < 4; i++)
        cfg(i, 1'(((j * 5 + 3) >> i) & 1), 1'(i == (j % 4)),
            32'h300 + 32'(j * 16 + i * 4), 32'(j) * 32'h1111_1111 + 32'(i * 8));
      root(32'hFFFF_FF00 + 32'(j) * 32'h48);
      expect_iter(32'hFFFF_FF00 + 32'(j) * 32'h48);
      drain("R5 sweep");
    end

    // R8: full queue stalls issue without loss
    for (int i = 0; i < 4; i++) cfg(i, 1'b1, 1'(i == 1), 32'h200 + 32'(i * 4), 32'(i * 4));
    root(32'h0000_3000);
    cyc(10);
    ret(32'h0000_4000);
    cyc(10);
    chk(pfq_addr == 32'h0000_3000, "R8 head held during stall", pfq_addr, 32'h0000_3000);
    expect_iter(32'h0000_3000);
    expect_iter(32'h0000_4000);
    drain("R8");

    // R9: base buffer full drops the extra pointer
    root(32'h0000_5000);
    cyc(10);
    root(32'h0000_6000);
    cyc(3);
    root(32'h0000_7000);
    root(32'h0000_8000);
    root(32'h0000_9000);
    root(32'h0000_A000);
    root(32'h0000_B000);
    ret(32'h0000_B400);
    for (int b = 5; b <= 10; b++) expect_iter(32'(b) << 12);
    drain("R9");

    // R11: root and returned pointer together, root wins
    root_wr = 1'b1; root_addr = 32'h0000_C000;
    ret_valid = 1'b1; ret_ptr = 32'h0000_D000;
    @(negedge clk);
    root_wr = 1'b0; ret_valid = 1'b0;
    expect_iter(32'h0000_C000);
    drain("R11");

    // R12: kernel write during a stalled iteration applies later
    root(32'h0000_E000);
    cyc(10);
    root(32'h0000_F000);
    cyc(3);
    expect_iter(32'h0000_E000);
    expect_iter(32'h0000_F000);
    cfg(3, 1'b1, 1'b0, 32'h20c, 32'h40);
    cyc(2);
    while (e_addr.size() != 0) pop_check("R12 old kernel");
    root(32'h0001_0000);
    expect_iter(32'h0001_0000);
    drain("R12 new kernel");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule